// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. Software reaches it through a small register port. A control word holds an enable, a start/busy bit, a channel field, an interrupt enable and a sticky done flag. A 16-bit result word can be read and also written by software. A configuration word marks which pins are analog. A read-only port view returns the digital pin levels, with every analog pin forced to zero.

All timing is paced by a one-cycle conversion-clock tick from outside. While the block is enabled and idle, it holds the sample path open on the selected channel. A start closes the sample path and runs a 10-bit binary search. The search places a trial code on the DAC output and keeps each bit for which the comparator reports the input at or above that code. Two cleanup ticks follow the search. The block then writes the result, sets the flag and drops the busy bit. Software can cancel a running conversion by writing the busy bit low. The result is then left untouched, sampling stays closed for two ticks, and acquisition on the selected channel then resumes without further action.

Top module: `adc_sar_seq`

## Requirements
- R1: A start (write to address 0 with bit1 = 1 and bit0 = 1) is taken only if the enable was already 1 before that write and the block is acquiring. A start written while the enable is 0, or in the same write that sets the enable, leaves bit1 reading 0.
- R2: The search tests one bit per tick, from the MSB down. The first trial code on `dac_code` is 0x200. A bit is kept when `cmp_in` is 1. For a held input v in 0..1023, the final result is v.
- R3: A conversion takes 12 ticks: 10 bit steps and 2 cleanup ticks. Bit1 of the control word reads 1 from the start until the 12th tick.
- R4: At completion, the result word (address 1) holds the 10-bit code in bits 9:0 with bits 15:10 zero. The done flag (control bit7) is set, and bit1 clears.
- R5: Writing address 0 with bit0 = 1 and bit1 = 0 during a conversion stops it at once. Bit1 clears, the flag is not set, and the result word keeps its previous value.
- R6: After a stop, `sample_en` stays low for exactly 2 ticks. It then returns high on the selected channel without software action. A start written during those 2 ticks is ignored.
- R7: The done flag stays set until software writes 1 to control bit7. `irq` is the flag ANDed with control bit6.
- R8: A software write to the result word during a conversion takes effect at once, and the completed code replaces it at the end of that conversion.
- R9: A read of address 3 returns the pin levels with every pin whose bit is 1 in the analog configuration word (address 2) reading 0.
- R10: `chan_sel` follows control bits 5:2. The conversion of a channel does not depend on the inputs of the other channels.
- R11: After reset, the control word and the result word read 0, and `irq` and `sample_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Write address |
| reg_wdata | input | 16 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 16 | Read data (combinational) |
| tad_tick | input | 1 | One-cycle conversion-clock tick |
| cmp_in | input | 1 | Comparator: input at or above DAC level |
| dac_code | output | 10 | Trial code for the DAC |
| sample_en | output | 1 | Sample switch closed (acquiring) |
| chan_sel | output | 4 | Selected analog channel |
| pin_in | input | 12 | Digital pin levels |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on three properties of the inputs: there is a single write port, `tad_tick` lasts one cycle, and the comparator only ever sees the held sample. The bench keeps to this. It spaces its ticks three cycles apart and issues one register write at a time. It models the sample-and-hold by latching the selected channel only while `sample_en` is high. It never writes the result word in the cycle a conversion completes, so the case where hardware and software update the result at the same time does not arise.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int REG_W = 16;
    localparam int CH_W  = 4;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RESULT = 2'd1;
    localparam logic [1:0] ADDR_ACFG   = 2'd2;
    localparam logic [1:0] ADDR_PORT   = 2'd3;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ACQ,
        ST_CONV,
        ST_CLEAN,
        ST_RECOV
    } seq_state_e;

    // control word layout, MSB first: flag(7) ie(6) ch(5:2) go(1) en(0)
    typedef struct packed {
        logic            flag;
        logic            ie;
        logic [CH_W-1:0] ch;
        logic            go;
        logic            en;
    } ctrl_t;

    typedef struct packed {
        logic             we;
        logic [1:0]       addr;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic ctrl_t ctrl_of(logic [7:0] d);
        return ctrl_t'(d);
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(ctrl_t c);
        return {{(REG_W-8){1'b0}}, c};
    endfunction

    function automatic logic is_busy(seq_state_e s);
        return (s == ST_CONV) || (s == ST_CLEAN);
    endfunction

endpackage

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                step,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] sar_val,
    output logic [RES_BITS-1:0] dac_code
);

    localparam logic [RES_BITS-1:0] TOP_BIT = RES_BITS'(1) << (RES_BITS - 1);

    logic [RES_BITS-1:0] trial;

    always_ff @(posedge clk) begin
        if (rst)
            trial <= '0;
        else if (start)
            trial <= TOP_BIT;
        else if (step)
            trial <= trial >> 1;
    end

    for (genvar b = 0; b < RES_BITS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || start)
                sar_val[b] <= 1'b0;
            else if (step && trial[b])
                sar_val[b] <= cmp_in;
        end
    end

    assign dac_code = sar_val | trial;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS   = 10,
    parameter int CLEAN_TADS = 2,
    parameter int RECOV_TADS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tad_tick,
    input  logic       en_q,
    input  logic       ctrl_we,
    input  logic       w_en,
    input  logic       w_go,
    output seq_state_e state,
    output logic       start,
    output logic       step,
    output logic       done,
    output logic       busy,
    output logic       sample_en
);

    localparam int MAXC  = max3(RES_BITS, CLEAN_TADS, RECOV_TADS);
    localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic [CNT_W-1:0] cnt;
    logic             off_req;
    logic             cancel;
    logic             last;

    assign busy      = is_busy(state);
    assign off_req   = ctrl_we && !w_en;
    assign cancel    = busy && ctrl_we && !(w_en && w_go);
    assign start     = ctrl_we && w_en && w_go && en_q && (state == ST_ACQ);
    assign last      = (cnt == '0);
    assign step      = (state == ST_CONV) && tad_tick && !cancel;
    assign done      = (state == ST_CLEAN) && tad_tick && last && !cancel;
    assign sample_en = (state == ST_ACQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else if (off_req) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    if (en_q)
                        state <= ST_ACQ;
                end
                ST_ACQ: begin
                    if (start) begin
                        state <= ST_CONV;
                        cnt   <= CNT_W'(RES_BITS - 1);
                    end
                end
                ST_CONV: begin
                    if (cancel) begin
                        state <= ST_RECOV;
                        cnt   <= CNT_W'(RECOV_TADS - 1);
                    end else if (tad_tick) begin
                        if (last) begin
                            state <= ST_CLEAN;
                            cnt   <= CNT_W'(CLEAN_TADS - 1);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_CLEAN: begin
                    if (cancel) begin
                        state <= ST_RECOV;
                        cnt   <= CNT_W'(RECOV_TADS - 1);
                    end else if (tad_tick) begin
                        if (last)
                            state <= ST_ACQ;
                        else
                            cnt <= cnt - 1'b1;
                    end
                end
                ST_RECOV: begin
                    if (tad_tick) begin
                        if (last)
                            state <= ST_ACQ;
                        else
                            cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int PINS     = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  reg_wr_t             wr,
    input  logic                ctrl_we,
    input  ctrl_t               wctl,
    input  logic [1:0]          raddr,
    input  logic                busy,
    input  logic                done,
    input  logic [RES_BITS-1:0] sar_val,
    input  logic [PINS-1:0]     pin_in,
    output logic [REG_W-1:0]    rdata,
    output logic                en_q,
    output logic [CH_W-1:0]     ch_q,
    output logic                flag_q,
    output logic [REG_W-1:0]    result_q,
    output logic                irq
);

    logic            ie_q;
    logic [PINS-1:0] acfg_q;
    logic [PINS-1:0] port_view;
    logic [REG_W-1:0] res_ext;
    ctrl_t           ctrl_rd;

    always_comb begin
        res_ext = '0;
        res_ext[RES_BITS-1:0] = sar_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            ie_q   <= 1'b0;
            ch_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_we) begin
                en_q <= wctl.en;
                ie_q <= wctl.ie;
                ch_q <= wctl.ch;
            end
            if (done)
                flag_q <= 1'b1;
            else if (ctrl_we && wctl.flag)
                flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            result_q <= '0;
        else if (done)
            result_q <= res_ext;
        else if (wr.we && wr.addr == ADDR_RESULT)
            result_q <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acfg_q <= '0;
        else if (wr.we && wr.addr == ADDR_ACFG)
            acfg_q <= wr.data[PINS-1:0];
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign port_view[p] = acfg_q[p] ? 1'b0 : pin_in[p];
    end

    assign ctrl_rd = '{flag: flag_q, ie: ie_q, ch: ch_q, go: busy, en: en_q};
    assign irq     = flag_q && ie_q;

    always_comb begin
        rdata = '0;
        case (raddr)
            ADDR_CTRL:   rdata = ctrl_word(ctrl_rd);
            ADDR_RESULT: rdata = result_q;
            ADDR_ACFG:   rdata[PINS-1:0] = acfg_q;
            default:     rdata[PINS-1:0] = port_view;
        endcase
    end

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS   = 10,
    parameter int PINS       = 12,
    parameter int CLEAN_TADS = 2,
    parameter int RECOV_TADS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic [1:0]          reg_raddr,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                tad_tick,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic                sample_en,
    output logic [CH_W-1:0]     chan_sel,
    input  logic [PINS-1:0]     pin_in,
    output logic                irq
);

    reg_wr_t             wr;
    ctrl_t               wctl;
    logic                ctrl_we;
    seq_state_e          st;
    logic                start, step, done, busy;
    logic                en_q, flag_q;
    logic [REG_W-1:0]    result_q;
    logic [RES_BITS-1:0] sar_val;

    assign wr      = '{we: reg_we, addr: reg_addr, data: reg_wdata};
    assign wctl    = ctrl_of(reg_wdata[7:0]);
    assign ctrl_we = reg_we && (reg_addr == ADDR_CTRL);

    adc_seq_fsm #(
        .RES_BITS  (RES_BITS),
        .CLEAN_TADS(CLEAN_TADS),
        .RECOV_TADS(RECOV_TADS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tad_tick (tad_tick),
        .en_q     (en_q),
        .ctrl_we  (ctrl_we),
        .w_en     (wctl.en),
        .w_go     (wctl.go),
        .state    (st),
        .start    (start),
        .step     (step),
        .done     (done),
        .busy     (busy),
        .sample_en(sample_en)
    );

    adc_sar_core #(
        .RES_BITS(RES_BITS)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .step    (step),
        .cmp_in  (cmp_in),
        .sar_val (sar_val),
        .dac_code(dac_code)
    );

    adc_seq_regs #(
        .RES_BITS(RES_BITS),
        .PINS    (PINS)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .ctrl_we (ctrl_we),
        .wctl    (wctl),
        .raddr   (reg_raddr),
        .busy    (busy),
        .done    (done),
        .sar_val (sar_val),
        .pin_in  (pin_in),
        .rdata   (reg_rdata),
        .en_q    (en_q),
        .ch_q    (chan_sel),
        .flag_q  (flag_q),
        .result_q(result_q),
        .irq     (irq)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS   = 10,
    parameter int CLEAN_TADS = 2
) (
    input logic                clk,
    input logic                rst,
    input seq_state_e          st,
    input logic                busy,
    input logic                en_q,
    input logic                sample_en,
    input logic                tad_tick,
    input logic                flag,
    input logic [REG_W-1:0]    result,
    input logic [RES_BITS-1:0] sar_val,
    input logic [RES_BITS-1:0] dac_code,
    input logic                reg_we,
    input logic [1:0]          reg_addr,
    input logic [REG_W-1:0]    reg_wdata
);

    localparam logic [7:0] TOTAL_TADS = 8'(RES_BITS + CLEAN_TADS);

    logic [7:0] tick_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            tick_cnt <= '0;
        else if (tad_tick)
            tick_cnt <= tick_cnt + 8'd1;
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(en_q) && $past(st == ST_ACQ)));  // R1

    AST_ONE_TRIAL_BIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CONV) |-> ($countones(dac_code & ~sar_val) == 1));  // R2

    AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && st == ST_ACQ) |-> (tick_cnt == TOTAL_TADS));  // R3

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && st == ST_ACQ) |-> flag);  // R4

    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && st == ST_ACQ) |->
            (result[RES_BITS-1:0] == $past(sar_val) && (result >> RES_BITS) == '0));  // R4

    AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECOV && $past(busy)) |-> $stable(result));  // R5

    AST_RECOV_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($rose(sample_en) && $past(st == ST_RECOV)) |-> $past(tad_tick));  // R6

    AST_FLAG_CLEAR_BY_SW: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(reg_we && reg_addr == ADDR_CTRL && reg_wdata[7]));  // R7

endmodule

bind adc_sar_seq adc_seq_chk #(
    .RES_BITS  (RES_BITS),
    .CLEAN_TADS(CLEAN_TADS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .busy     (busy),
    .en_q     (en_q),
    .sample_en(sample_en),
    .tad_tick (tad_tick),
    .flag     (flag_q),
    .result   (result_q),
    .sar_val  (sar_val),
    .dac_code (dac_code),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata)
);

// File: tb/sim_adc_sar_seq.sv
module sim_adc_sar_seq;
    import adc_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [15:0] reg_rdata;
    logic        tad_tick = 1'b0;
    logic        cmp_in;
    logic [9:0]  dac_code;
    logic        sample_en;
    logic [3:0]  chan_sel;
    logic [11:0] pin_in = '0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    logic [9:0] ana [16];
    logic [9:0] held = '0;

    always #4 clk = ~clk;

    adc_sar_seq u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .tad_tick(tad_tick), .cmp_in(cmp_in), .dac_code(dac_code),
        .sample_en(sample_en), .chan_sel(chan_sel), .pin_in(pin_in), .irq(irq)
    );

    // sample-and-hold and comparator model
    always @(posedge clk) if (sample_en) held <= ana[chan_sel];
    assign cmp_in = (held >= dac_code);

    typedef struct packed {
        logic [3:0] ch;
        logic [9:0] val;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  10'd0},
        '{4'd3,  10'd1023},
        '{4'd7,  10'd512},
        '{4'd11, 10'd511},
        '{4'd15, 10'd682},
        '{4'd4,  10'd341}
    };

    function automatic logic [15:0] mk(bit en, bit go, logic [3:0] ch, bit ie, bit fl);
        return {8'h00, fl, ie, ch, go, en};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_raddr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tad_tick = 1'b1;
            @(negedge clk); tad_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic arm(input logic [3:0] ch, input bit ie);
        wr(ADDR_CTRL, mk(1, 0, ch, ie, 0));
        repeat (2) @(negedge clk);
        wr(ADDR_CTRL, mk(1, 1, ch, ie, 0));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] d;
        for (int k = 0; k < 16; k++) ana[k] = 10'(16 * k + 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(ADDR_CTRL, d);   chk("R11 ctrl after reset", d, 16'h0000);
        rd(ADDR_RESULT, d); chk("R11 result after reset", d, 16'h0000);
        chk("R11 irq after reset", 16'(irq), 16'd0);
        chk("R11 sample_en after reset", 16'(sample_en), 16'd0);

        // R1 start ignored while disabled, and in the enabling write
        wr(ADDR_CTRL, mk(0, 1, 0, 0, 0));
        rd(ADDR_CTRL, d); chk("R1 go with enable low", d, 16'h0000);
        wr(ADDR_CTRL, mk(1, 1, 0, 0, 0));
        rd(ADDR_CTRL, d); chk("R1 go in enabling write", d, mk(1, 0, 0, 0, 0));
        ticks(12);
        rd(ADDR_CTRL, d); chk("R1 no conversion ran", d, mk(1, 0, 0, 0, 0));

        // vector table: R2 R3 R4 R7 R10
        for (int i = 0; i < NV; i++) begin
            ana[VECS[i].ch] = VECS[i].val;
            arm(VECS[i].ch, 1);
            rd(ADDR_CTRL, d); chk("R1 start accepted", d, mk(1, 1, VECS[i].ch, 1, 0));
            chk("R10 chan_sel", 16'(chan_sel), 16'(VECS[i].ch));
            chk("R2 first trial", 16'(dac_code), 16'h0200);
            ticks(1);
            chk("R2 second trial", 16'(dac_code), 16'((VECS[i].val & 10'h200) | 10'h100));
            ticks(10);
            rd(ADDR_CTRL, d); chk("R3 busy at tick 11", d, mk(1, 1, VECS[i].ch, 1, 0));
            ticks(1);
            rd(ADDR_RESULT, d); chk("R2 R4 result", d, {6'b0, VECS[i].val});
            rd(ADDR_CTRL, d); chk("R4 flag set go clear", d, mk(1, 0, VECS[i].ch, 1, 1));
            chk("R7 irq raised", 16'(irq), 16'd1);
            wr(ADDR_CTRL, mk(1, 0, VECS[i].ch, 1, 1));
            chk("R7 irq after clear", 16'(irq), 16'd0);
        end

        // R5 R6 abort and recovery
        wr(ADDR_RESULT, 16'h1234);
        rd(ADDR_RESULT, d); chk("R8 software result write", d, 16'h1234);
        ana[2] = 10'd300;
        arm(4'd2, 1);
        ticks(5);
        wr(ADDR_CTRL, mk(1, 0, 2, 1, 0));
        rd(ADDR_CTRL, d);   chk("R5 go cleared by abort", d, mk(1, 0, 2, 1, 0));
        rd(ADDR_RESULT, d); chk("R5 result kept", d, 16'h1234);
        chk("R6 sampling closed", 16'(sample_en), 16'd0);
        wr(ADDR_CTRL, mk(1, 1, 2, 1, 0));
        rd(ADDR_CTRL, d);   chk("R6 go ignored in recovery", d, mk(1, 0, 2, 1, 0));
        ticks(1);
        chk("R6 closed after 1 tick", 16'(sample_en), 16'd0);
        ticks(1);
        chk("R6 reopened after 2 ticks", 16'(sample_en), 16'd1);
        chk("R6 channel kept", 16'(chan_sel), 16'd2);
        arm(4'd2, 1);
        ticks(12);
        rd(ADDR_RESULT, d); chk("R6 restart converts", d, 16'd300);
        wr(ADDR_CTRL, mk(1, 0, 2, 1, 1));

        // R8 software write mid-conversion
        ana[5] = 10'd777;
        arm(4'd5, 1);
        ticks(3);
        wr(ADDR_RESULT, 16'hBEEF);
        rd(ADDR_RESULT, d); chk("R8 write accepted mid-conversion", d, 16'hBEEF);
        ticks(9);
        rd(ADDR_RESULT, d); chk("R8 overwritten at completion", d, 16'd777);
        wr(ADDR_CTRL, mk(1, 0, 5, 1, 1));

        // R7 interrupt enable gating and sticky flag
        ana[1] = 10'd1000;
        arm(4'd1, 0);
        ticks(12);
        rd(ADDR_CTRL, d); chk("R7 flag with ie low", d, mk(1, 0, 1, 0, 1));
        chk("R7 irq masked", 16'(irq), 16'd0);
        wr(ADDR_CTRL, mk(1, 0, 1, 1, 0));
        chk("R7 flag sticky irq on", 16'(irq), 16'd1);
        wr(ADDR_CTRL, mk(1, 0, 1, 1, 1));
        chk("R7 write-one clears", 16'(irq), 16'd0);

        // R9 port read masking
        wr(ADDR_ACFG, 16'h00F0);
        rd(ADDR_ACFG, d); chk("R9 analog config readback", d, 16'h00F0);
        pin_in = 12'hFFF;
        rd(ADDR_PORT, d); chk("R9 port all high", d, 16'h0F0F);
        pin_in = 12'hA5A;
        rd(ADDR_PORT, d); chk("R9 port pattern", d, 16'h0A0A);
        wr(ADDR_ACFG, 16'h0FFF);
        rd(ADDR_PORT, d); chk("R9 all analog", d, 16'h0000);

        summary();
        $finish;
    end

endmodule